// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Emulator

This block behaves like a small serial EEPROM of 16-bit words. It sits on a chip select, a serial clock and a data-in wire, and it answers on one data-out wire. It runs on the system clock. The serial clock is an ordinary input: the block detects its rising edges and acts on the cycle that sees each one. An instruction begins with a start bit of 1. A 2-bit opcode follows, then the address, then 16 data bits for the two kinds of write. Every shifted field arrives most significant bit first.

Reading returns one word. Writing and erasing work on one word or on the whole array. Two extended instructions set and clear a programming-enable latch, and that latch must be set before any programming instruction takes effect. A program or erase finishes in the cycle that takes in its last bit, so there is no busy time. The parameter `ADDR_W` chooses a 6-bit or an 8-bit address, which gives 64 or 256 words.

Top module: `mw_eeprom_emu`

## Requirements
- R1: After reset, every word reads 16'hFFFF, the programming-enable latch is clear and `dout` is 1.
- R2: An instruction starts on the first rising `sk` edge that samples `din`=1 while `cs` is high. Rising edges before that, with `din`=0, are ignored. The next 2 edges give the opcode, the next `ADDR_W` edges give the address, and the 16 edges after those give the data when the instruction carries data.
- R3: Opcode 2'b10 reads a word. On the edge that takes in the last address bit, `dout` goes to 0. Each of the next 16 rising edges puts out one word bit, most significant bit first. The 17th edge returns `dout` to 1.
- R4: Opcode 2'b01 with the latch set stores the 16 data bits into the addressed word.
- R5: Opcode 2'b11 with the latch set sets the addressed word to 16'hFFFF.
- R6: Opcode 2'b00 selects an extended instruction by the top two address bits. With those bits at 2'b11 the latch is set, and with them at 2'b00 the latch is cleared. The lower address bits have no effect.
- R7: With opcode 2'b00 and the latch set, top bits 2'b10 set every word to 16'hFFFF, and top bits 2'b01 write the 16 data bits into every word.
- R8: While the latch is clear, write, erase, erase-all and write-all leave every word unchanged.
- R9: When `cs` is low, the decoder drops any partly received instruction and waits for a new start bit. A rising edge in a cycle where `cs` is low has no effect.
- R10: Outside the read phase, `dout` stays at 1.
- R11: Falling `sk` edges do not move `dout` or the decoder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, sampled by clk |
| din | input | 1 | Serial instruction, address and data input |
| dout | output | 1 | Serial read data output |

## Verification
The last data edge of a write and the release of chip select can arrive in the same system clock cycle. The bench produces this by lowering `cs` in the same cycle that `sk` rises for the sixteenth data bit. It then reads the word back, and the word must hold its earlier value, because the abort takes priority. A second case drops `cs` part way through an address and then checks that the next full read decodes correctly.

// File: rtl/mw_pkg.sv
package mw_pkg;

   localparam int WORD_W = 16;

   typedef enum logic [2:0] {
      ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_DONE
   } mw_state_e;

   typedef enum logic [2:0] {
      K_NONE, K_READ, K_WRITE, K_ERASE, K_ERAL, K_WRAL, K_PEN, K_PDIS
   } mw_kind_e;

   function automatic mw_kind_e mw_decode(input logic [1:0] opc, input logic [1:0] ext);
      mw_kind_e k;
      case (opc)
         2'b10:   k = K_READ;
         2'b01:   k = K_WRITE;
         2'b11:   k = K_ERASE;
         default: begin
            case (ext)
               2'b11:   k = K_PEN;
               2'b10:   k = K_ERAL;
               2'b01:   k = K_WRAL;
               default: k = K_PDIS;
            endcase
         end
      endcase
      return k;
   endfunction

endpackage

// File: rtl/mw_frame.sv
module mw_frame
   import mw_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs,
   input  logic                rise,
   input  logic                din,
   output logic                go,
   output mw_kind_e            kind,
   output logic [ADDR_W-1:0]   addr_o,
   output logic [WORD_W-1:0]   data_o,
   output logic                rd_load,
   output logic                rd_shift,
   output logic                rd_stop
);
   localparam int CW = $clog2(WORD_W + 2);
   localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_W - 1);
   localparam logic [CW-1:0] DATA_LAST = CW'(WORD_W - 1);
   localparam logic [CW-1:0] READ_LAST = CW'(WORD_W);

   mw_state_e          state_q;
   logic [CW-1:0]      cnt_q;
   logic [1:0]         opc_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [WORD_W-1:0]  data_q;

   logic               edge_ok;
   logic               addr_last;
   logic               data_last;
   logic [ADDR_W-1:0]  addr_full;
   mw_kind_e           kind_new;
   mw_kind_e           kind_reg;
   mw_state_e          after_addr;

   assign edge_ok   = cs && rise;
   assign addr_full = {addr_q[ADDR_W-2:0], din};
   assign addr_last = edge_ok && (state_q == ST_ADDR) && (cnt_q == ADDR_LAST);
   assign data_last = edge_ok && (state_q == ST_DATA) && (cnt_q == DATA_LAST);
   assign kind_new  = mw_decode(opc_q, addr_full[ADDR_W-1 -: 2]);
   assign kind_reg  = mw_decode(opc_q, addr_q[ADDR_W-1 -: 2]);

   always_comb begin
      case (kind_new)
         K_READ:          after_addr = ST_READ;
         K_WRITE, K_WRAL: after_addr = ST_DATA;
         default:         after_addr = ST_DONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         opc_q   <= '0;
         addr_q  <= '0;
         data_q  <= '0;
      end else if (!cs) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else if (rise) begin
         case (state_q)
            ST_IDLE: if (din) begin
               state_q <= ST_OPC;
               cnt_q   <= '0;
            end
            ST_OPC: begin
               opc_q <= {opc_q[0], din};
               if (cnt_q == CW'(1)) begin
                  state_q <= ST_ADDR;
                  cnt_q   <= '0;
               end else cnt_q <= cnt_q + 1'b1;
            end
            ST_ADDR: begin
               addr_q <= addr_full;
               if (cnt_q == ADDR_LAST) begin
                  state_q <= after_addr;
                  cnt_q   <= '0;
               end else cnt_q <= cnt_q + 1'b1;
            end
            ST_DATA: begin
               data_q <= {data_q[WORD_W-2:0], din};
               if (cnt_q == DATA_LAST) state_q <= ST_DONE;
               else cnt_q <= cnt_q + 1'b1;
            end
            ST_READ: begin
               if (cnt_q == READ_LAST) state_q <= ST_DONE;
               else cnt_q <= cnt_q + 1'b1;
            end
            default: state_q <= ST_DONE;
         endcase
      end
   end

   always_comb begin
      go = 1'b0;
      if (data_last) go = 1'b1;
      if (addr_last && (after_addr == ST_DONE)) go = 1'b1;
   end

   assign kind     = addr_last ? kind_new : kind_reg;
   assign addr_o   = addr_last ? addr_full : addr_q;
   assign data_o   = {data_q[WORD_W-2:0], din};
   assign rd_load  = addr_last && (kind_new == K_READ);
   assign rd_shift = edge_ok && (state_q == ST_READ) && (cnt_q != READ_LAST);
   assign rd_stop  = edge_ok && (state_q == ST_READ) && (cnt_q == READ_LAST);

   // R9
   cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> (state_q == ST_IDLE));

   // R2
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && rise && !din) |=> (state_q == ST_IDLE));

   // R11
   no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && $past(cs) && !rise) |=> ($stable(state_q) && $stable(cnt_q)));

endmodule

// File: rtl/mw_array.sv
module mw_array
   import mw_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  mw_kind_e            kind,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [WORD_W-1:0]   data,
   output logic [WORD_W-1:0]   rd_word
);
   localparam int WORDS = 2 ** ADDR_W;

   logic [WORD_W-1:0] mem_q [WORDS];
   logic [WORDS-1:0]  we;
   logic              pen_q;
   logic              prog;
   logic              one_hit;
   logic              all_hit;
   logic              erase_val;

   assign prog      = go && pen_q;
   assign one_hit   = prog && (kind == K_WRITE || kind == K_ERASE);
   assign all_hit   = prog && (kind == K_WRAL || kind == K_ERAL);
   assign erase_val = (kind == K_ERASE) || (kind == K_ERAL);

   for (genvar i = 0; i < WORDS; i++) begin : g_we
      assign we[i] = all_hit || (one_hit && (addr == ADDR_W'(i)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pen_q <= 1'b0;
         for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
      end else begin
         if (go && kind == K_PEN)  pen_q <= 1'b1;
         if (go && kind == K_PDIS) pen_q <= 1'b0;
         for (int i = 0; i < WORDS; i++) begin
            if (we[i]) mem_q[i] <= erase_val ? '1 : data;
         end
      end
   end

   assign rd_word = mem_q[addr];

   // R8
   locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !pen_q && kind == K_WRITE) |=> (mem_q[$past(addr)] == $past(mem_q[addr])));

   // R5
   erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && pen_q && kind == K_ERASE) |=> (mem_q[$past(addr)] == '1));

   // R4
   write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && pen_q && kind == K_WRITE) |=> (mem_q[$past(addr)] == $past(data)));

endmodule

// File: rtl/mw_readout.sv
module mw_readout
   import mw_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs,
   input  logic               load,
   input  logic               shift,
   input  logic               stop,
   input  logic [WORD_W-1:0]  word,
   output logic               dout
);
   logic [WORD_W-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout <= 1'b1;
         sh_q <= '0;
      end else if (!cs) begin
         dout <= 1'b1;
      end else if (load) begin
         dout <= 1'b0;
         sh_q <= word;
      end else if (shift) begin
         dout <= sh_q[WORD_W-1];
         sh_q <= {sh_q[WORD_W-2:0], 1'b0};
      end else if (stop) begin
         dout <= 1'b1;
      end
   end

   // R3
   lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && load) |=> !dout);

   // R10
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs || stop) |=> dout);

endmodule

// File: rtl/mw_eeprom_emu.sv
module mw_eeprom_emu
   import mw_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sk,
   input  logic din,
   output logic dout
);
   if (!(ADDR_W == 6 || ADDR_W == 8)) begin : g_bad_addr_w
      $error("ADDR_W must be 6 or 8");
   end

   logic               sk_q;
   logic               rise;
   logic               go;
   mw_kind_e           kind;
   logic [ADDR_W-1:0]  addr;
   logic [WORD_W-1:0]  data;
   logic [WORD_W-1:0]  rd_word;
   logic               rd_load;
   logic               rd_shift;
   logic               rd_stop;

   always_ff @(posedge clk) begin
      if (!rst_n) sk_q <= 1'b0;
      else        sk_q <= sk;
   end

   assign rise = sk && !sk_q;

   mw_frame #(.ADDR_W(ADDR_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .cs(cs), .rise(rise), .din(din),
      .go(go), .kind(kind), .addr_o(addr), .data_o(data),
      .rd_load(rd_load), .rd_shift(rd_shift), .rd_stop(rd_stop)
   );

   mw_array #(.ADDR_W(ADDR_W)) u_array (
      .clk(clk), .rst_n(rst_n), .go(go), .kind(kind),
      .addr(addr), .data(data), .rd_word(rd_word)
   );

   mw_readout u_readout (
      .clk(clk), .rst_n(rst_n), .cs(cs), .load(rd_load),
      .shift(rd_shift), .stop(rd_stop), .word(rd_word), .dout(dout)
   );

   // R1
   rst_out_chk: assert property (@(posedge clk) $past(!rst_n) |-> dout);

endmodule

// File: tb/mw_eeprom_emu_tb.sv
`timescale 1ns/1ps
module mw_eeprom_emu_tb;
   localparam int AW = 6;
   localparam int NW = 2 ** AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0;
   logic sk = 1'b0;
   logic din = 1'b0;
   logic dout;

   always #2 clk = ~clk;

   mw_eeprom_emu #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .din(din), .dout(dout)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   logic [15:0] model [NW];
   bit pen = 0;

   logic [15:0] exp_q [$];
   logic [15:0] got_q [$];
   string       tag_q [$];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic sbit(input logic b);
      @(negedge clk) begin din = b; sk = 1'b0; end
      @(negedge clk);
      @(negedge clk) sk = 1'b1;
      @(negedge clk);
   endtask

   task automatic sbits(input logic [15:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) sbit(v[i]);
   endtask

   task automatic cs_on();
      @(negedge clk) begin cs = 1'b1; sk = 1'b0; end
      @(negedge clk);
   endtask

   task automatic cs_off();
      @(negedge clk) begin cs = 1'b0; sk = 1'b0; end
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic hdr(input logic [1:0] opc, input logic [AW-1:0] a, input int lead);
      cs_on();
      for (int i = 0; i < lead; i++) sbit(1'b0);
      sbit(1'b1);
      sbits({14'd0, opc}, 2);
      sbits({{(16-AW){1'b0}}, a}, AW);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d, input int lead);
      hdr(2'b01, a, lead);
      chk(dout === 1'b1, "R10 dout idle during write", {31'd0, dout}, 32'd1);
      sbits(d, 16);
      cs_off();
      if (pen) model[a] = d;
   endtask

   task automatic do_erase(input logic [AW-1:0] a);
      hdr(2'b11, a, 0);
      cs_off();
      if (pen) model[a] = 16'hFFFF;
   endtask

   task automatic do_ext(input logic [1:0] code, input logic [15:0] d);
      hdr(2'b00, {code, 4'b1010}, 0);
      if (code == 2'b01) sbits(d, 16);
      cs_off();
      case (code)
         2'b11: pen = 1;
         2'b00: pen = 0;
         2'b10: if (pen) for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
         default: if (pen) for (int i = 0; i < NW; i++) model[i] = d;
      endcase
   endtask

   task automatic do_read(input logic [AW-1:0] a, input string tag);
      logic [15:0] w;
      logic held;
      hdr(2'b10, a, 0);
      chk(dout === 1'b0, "R3 leading zero", {31'd0, dout}, 32'd0);
      w = '0;
      for (int i = 0; i < 16; i++) begin
         sbit(1'b0);
         w = {w[14:0], dout};
         if (i == 0) begin
            held = dout;
            @(negedge clk) sk = 1'b0;
            @(negedge clk);
            @(negedge clk);
            chk(dout === held, "R11 falling edge keeps dout", {31'd0, dout}, {31'd0, held});
         end
      end
      sbit(1'b0);
      chk(dout === 1'b1, "R3 dout high after word", {31'd0, dout}, 32'd1);
      cs_off();
      exp_q.push_back(model[a]);
      got_q.push_back(w);
      tag_q.push_back(tag);
   endtask

   always @(negedge clk) begin
      if (got_q.size() > 0 && exp_q.size() > 0) begin
         logic [15:0] g;
         logic [15:0] e;
         string t;
         g = got_q.pop_front();
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(g === e, t, {16'd0, g}, {16'd0, e});
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dout === 1'b1, "R1 dout after reset", {31'd0, dout}, 32'd1);

      do_read(6'd3, "R1 word erased at reset");
      do_write(6'd3, 16'h1234, 0);
      do_read(6'd3, "R8 write ignored with latch clear");

      do_ext(2'b11, 16'h0);
      do_write(6'd3, 16'hA5C3, 0);
      do_read(6'd3, "R4 write stores word");
      do_read(6'd3, "R6 enable with don't-care low bits");

      do_write(6'd7, 16'h0F0F, 3);
      do_read(6'd7, "R2 leading zeros before start ignored");

      do_erase(6'd3);
      do_read(6'd3, "R5 erase gives FFFF");

      do_ext(2'b01, 16'h5A5A);
      do_read(6'd0, "R7 write-all word 0");
      do_read(6'd63, "R7 write-all word 63");

      do_write(6'd10, 16'hBEEF, 0);
      do_ext(2'b10, 16'h0);
      do_read(6'd10, "R7 erase-all");

      // R9: chip select falls in the same cycle as the final data edge
      do_write(6'd9, 16'h1357, 0);
      hdr(2'b01, 6'd9, 0);
      sbits(16'h2468 >> 1, 15);
      @(negedge clk) begin din = 1'b0; sk = 1'b0; end
      @(negedge clk);
      @(negedge clk) begin sk = 1'b1; cs = 1'b0; end
      @(negedge clk);
      cs_off();
      do_read(6'd9, "R9 coincident abort keeps word");

      // R9: abort in the middle of an address
      cs_on();
      sbit(1'b1);
      sbits(16'h2, 2);
      sbits(16'h5, 3);
      cs_off();
      do_read(6'd9, "R9 clean decode after mid-address abort");

      do_ext(2'b00, 16'h0);
      do_write(6'd9, 16'h0000, 0);
      do_read(6'd9, "R8 write ignored after disable (R6)");
      do_erase(6'd9);
      do_read(6'd9, "R8 erase ignored after disable");

      repeat (4) @(negedge clk);
      chk(got_q.size() == 0, "R3 all reads compared", got_q.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule